// File: doc/BRIEF.md
# Peripheral Idle Handshake Agent

This block lives inside a peripheral and answers the idle request sent by a central power and clock manager. A two-bit idle policy, set by software, picks how the agent replies. The agent can grant idle at once, refuse it, or grant it only after the peripheral's own work has finished. That work is pending bus transactions, reported as a count, pending interrupt lines and pending DMA request lines.

When idle is granted, the agent holds its acknowledge until the manager withdraws the request. In the wakeup-capable policy, a fresh interrupt or DMA event that arrives while idle raises a wakeup level back to the manager. A build parameter can remove the wakeup path entirely. When the request drops, the acknowledge and the wakeup both clear on the next clock edge, and the agent is active again.

Top module: `idle_agent`

## Requirements
- R1: With policy 0 (force), an asserted idle request makes the acknowledge high on the next clock edge, whatever the activity inputs show.
- R2: With policy 2 (smart), the acknowledge rises only on the clock edge that samples the request high together with a transaction count of zero, no interrupt line high and no DMA line high.
- R3: With policy 3 (smart with wakeup), the acknowledge follows the same drain rule as R2. While the acknowledge is high, a rising level on any interrupt or DMA line sets the wakeup output on the next edge.
- R4: The wakeup output never rises under policies 0, 1 or 2, or when the parameter WAKEUP_EN is 0. In that build, policy 3 behaves like policy 2.
- R5: With policy 1 (no-idle), the acknowledge never rises from the non-acknowledged state.
- R6: Once the wakeup output is high, it stays high for as long as the idle request stays high.
- R7: One edge after the idle request is sampled low, both the acknowledge and the wakeup output are low.
- R8: Under the smart policies, activity that appears after the request but before the acknowledge keeps the acknowledge low until that activity has drained again.
- R9: After reset the acknowledge and the wakeup output are low.
- R10: Once the acknowledge is high, it stays high while the request stays high, whatever the activity inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| idle_policy | input | 2 | 0 force, 1 no-idle, 2 smart, 3 smart with wakeup |
| idle_req | input | 1 | Idle request from the power manager |
| txn_count | input | TXN_CNT_W | Number of outstanding bus transactions |
| irq_pend | input | IRQ_N | Pending interrupt lines |
| dma_pend | input | DMA_N | Pending DMA request lines |
| idle_ack | output | 1 | Idle acknowledge (registered) |
| wakeup | output | 1 | Wakeup request level (registered) |

## Verification
Two situations are the hardest to reach from the ports. The first is wakeup after idle has been granted: the drain rule requires every interrupt and DMA line to be low at grant time, so the stimulus first drains all activity under policy 3, waits for the acknowledge, and only then raises a single interrupt line. The second is activity that reappears during the drain. To reach it, a vector sequence clears the transaction count in the same cycle that an interrupt rises, so the acknowledge has to wait one further cycle. A second instance built with WAKEUP_EN set to 0 receives the same stimulus, which shows that its wakeup output stays low.

// File: rtl/idle_agent_pkg.sv
package idle_agent_pkg;

    typedef enum logic [1:0] {
        POL_FORCE  = 2'd0,
        POL_NOIDLE = 2'd1,
        POL_SMART  = 2'd2,
        POL_SMARTW = 2'd3
    } idle_pol_e;

    typedef enum logic [1:0] {
        ST_ACTIVE = 2'd0,
        ST_DRAIN  = 2'd1,
        ST_IDLE   = 2'd2
    } agent_st_e;

    typedef struct packed {
        agent_st_e st;
        logic      ack;
        logic      wake;
    } agent_reg_t;

endpackage

// File: rtl/idle_policy_dec.sv
module idle_policy_dec #(
    parameter bit WAKEUP_EN = 1'b1
) (
    input  logic [1:0] policy,
    output logic       pol_force,
    output logic       pol_smart,
    output logic       pol_wake
);
    import idle_agent_pkg::*;

    logic wake_req;

    always_comb begin
        pol_force = (idle_pol_e'(policy) == POL_FORCE);
        pol_smart = (idle_pol_e'(policy) == POL_SMART) ||
                    (idle_pol_e'(policy) == POL_SMARTW);
        wake_req  = (idle_pol_e'(policy) == POL_SMARTW);
    end

    generate
        if (WAKEUP_EN) begin : g_wake
            assign pol_wake = wake_req;
        end else begin : g_nowake
            logic unused_wake;
            assign unused_wake = wake_req;
            assign pol_wake    = 1'b0;
        end
    endgenerate
endmodule

// File: rtl/idle_activity_mon.sv
module idle_activity_mon #(
    parameter int TXN_CNT_W = 4,
    parameter int IRQ_N     = 4,
    parameter int DMA_N     = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [TXN_CNT_W-1:0] txn_count,
    input  logic [IRQ_N-1:0]     irq_pend,
    input  logic [DMA_N-1:0]     dma_pend,
    output logic                 busy,
    output logic                 new_event
);
    localparam int LINES = IRQ_N + DMA_N;

    logic [LINES-1:0] lines;
    logic [LINES-1:0] prev_d, prev_q;

    always_comb begin
        lines     = {irq_pend, dma_pend};
        busy      = (|txn_count) || (|lines);
        new_event = |(lines & ~prev_q);
        prev_d    = lines;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/idle_agent.sv
module idle_agent #(
    parameter int TXN_CNT_W = 4,
    parameter int IRQ_N     = 4,
    parameter int DMA_N     = 2,
    parameter bit WAKEUP_EN = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [1:0]           idle_policy,
    input  logic                 idle_req,
    input  logic [TXN_CNT_W-1:0] txn_count,
    input  logic [IRQ_N-1:0]     irq_pend,
    input  logic [DMA_N-1:0]     dma_pend,
    output logic                 idle_ack,
    output logic                 wakeup
);
    import idle_agent_pkg::*;

    logic pol_force, pol_smart, pol_wake;
    logic busy, new_event;
    logic grant;
    agent_reg_t r_d, r_q;

    idle_policy_dec #(.WAKEUP_EN(WAKEUP_EN)) u_dec (
        .policy    (idle_policy),
        .pol_force (pol_force),
        .pol_smart (pol_smart),
        .pol_wake  (pol_wake)
    );

    idle_activity_mon #(
        .TXN_CNT_W (TXN_CNT_W),
        .IRQ_N     (IRQ_N),
        .DMA_N     (DMA_N)
    ) u_mon (
        .clk       (clk),
        .rst_n     (rst_n),
        .txn_count (txn_count),
        .irq_pend  (irq_pend),
        .dma_pend  (dma_pend),
        .busy      (busy),
        .new_event (new_event)
    );

    always_comb begin
        r_d   = r_q;
        grant = pol_force || (pol_smart && !busy);
        unique case (r_q.st)
            ST_IDLE: begin
                if (!idle_req) r_d.st = ST_ACTIVE;
            end
            default: begin
                if (!idle_req)                     r_d.st = ST_ACTIVE;
                else if (grant)                    r_d.st = ST_IDLE;
                else if (pol_smart)                r_d.st = ST_DRAIN;
                else                               r_d.st = ST_ACTIVE;
            end
        endcase
        r_d.ack  = (r_d.st == ST_IDLE);
        r_d.wake = (r_d.st == ST_IDLE) &&
                   (r_q.wake || ((r_q.st == ST_IDLE) && pol_wake && new_event));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '{st: ST_ACTIVE, ack: 1'b0, wake: 1'b0};
        else        r_q <= r_d;
    end

    assign idle_ack = r_q.ack;
    assign wakeup   = r_q.wake;
endmodule

// File: rtl/idle_agent_chk.sv
module idle_agent_chk #(
    parameter int TXN_CNT_W = 4,
    parameter int IRQ_N     = 4,
    parameter int DMA_N     = 2,
    parameter bit WAKEUP_EN = 1'b1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [1:0]           idle_policy,
    input logic                 idle_req,
    input logic [TXN_CNT_W-1:0] txn_count,
    input logic [IRQ_N-1:0]     irq_pend,
    input logic [DMA_N-1:0]     dma_pend,
    input logic                 idle_ack,
    input logic                 wakeup
);
    logic act;
    assign act = (|txn_count) || (|irq_pend) || (|dma_pend);

    p_force_ack_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_req && idle_policy == 2'd0) |=> idle_ack);

    p_drain_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle_ack && idle_policy[1] && act) |=> !idle_ack);

    p_wake_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wakeup |-> idle_ack);

    p_nowake_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!wakeup && (idle_policy != 2'd3 || !WAKEUP_EN)) |=> !wakeup);

    p_noidle_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle_ack && idle_policy == 2'd1) |=> !idle_ack);

    p_wake_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wakeup && idle_req) |=> wakeup);

    p_exit_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !idle_req |=> (!idle_ack && !wakeup));

    p_ack_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_ack && idle_req) |=> idle_ack);
endmodule

bind idle_agent idle_agent_chk #(
    .TXN_CNT_W (TXN_CNT_W),
    .IRQ_N     (IRQ_N),
    .DMA_N     (DMA_N),
    .WAKEUP_EN (WAKEUP_EN)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .idle_policy (idle_policy),
    .idle_req    (idle_req),
    .txn_count   (txn_count),
    .irq_pend    (irq_pend),
    .dma_pend    (dma_pend),
    .idle_ack    (idle_ack),
    .wakeup      (wakeup)
);

// File: tb/tb_idle_agent.sv
module tb_idle_agent;
    localparam int NV = 22;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] pol = 2'd0;
    logic       req = 1'b0;
    logic [3:0] txn = '0;
    logic [3:0] irq = '0;
    logic [1:0] dma = '0;
    logic       ack, wake, ack_nw, wake_nw;
    int         n_run = 0;
    int         n_fail = 0;
    bit         done = 1'b0;

    always #4 clk = ~clk;

    idle_agent dut (
        .clk(clk), .rst_n(rst_n), .idle_policy(pol), .idle_req(req),
        .txn_count(txn), .irq_pend(irq), .dma_pend(dma),
        .idle_ack(ack), .wakeup(wake)
    );

    idle_agent #(.WAKEUP_EN(1'b0)) dut_nw (
        .clk(clk), .rst_n(rst_n), .idle_policy(pol), .idle_req(req),
        .txn_count(txn), .irq_pend(irq), .dma_pend(dma),
        .idle_ack(ack_nw), .wakeup(wake_nw)
    );

    // {policy, req, txn, irq, dma, exp_ack, exp_wake}
    localparam logic [14:0] VEC [NV] = '{
        {2'd2, 1'b1, 4'd3, 4'h0, 2'b00, 1'b0, 1'b0}, // R2 busy
        {2'd2, 1'b1, 4'd0, 4'h0, 2'b00, 1'b1, 1'b0}, // R2 drained
        {2'd2, 1'b1, 4'd0, 4'h1, 2'b00, 1'b1, 1'b0}, // R10 R4 no wake in smart
        {2'd2, 1'b0, 4'd0, 4'h0, 2'b00, 1'b0, 1'b0}, // R7
        {2'd0, 1'b1, 4'd5, 4'hF, 2'b11, 1'b1, 1'b0}, // R1 force with activity
        {2'd0, 1'b0, 4'd0, 4'h0, 2'b00, 1'b0, 1'b0}, // R7
        {2'd1, 1'b1, 4'd0, 4'h0, 2'b00, 1'b0, 1'b0}, // R5
        {2'd1, 1'b1, 4'd0, 4'h0, 2'b00, 1'b0, 1'b0}, // R5
        {2'd3, 1'b1, 4'd0, 4'h0, 2'b01, 1'b0, 1'b0}, // R3 drain
        {2'd3, 1'b1, 4'd0, 4'h0, 2'b00, 1'b1, 1'b0}, // R3 ack
        {2'd3, 1'b1, 4'd0, 4'h2, 2'b00, 1'b1, 1'b1}, // R3 wakeup
        {2'd3, 1'b1, 4'd0, 4'h0, 2'b00, 1'b1, 1'b1}, // R6 level
        {2'd3, 1'b1, 4'd7, 4'h0, 2'b10, 1'b1, 1'b1}, // R6 R10
        {2'd3, 1'b0, 4'd0, 4'h0, 2'b00, 1'b0, 1'b0}, // R7
        {2'd2, 1'b1, 4'd1, 4'h0, 2'b00, 1'b0, 1'b0}, // R8
        {2'd2, 1'b1, 4'd0, 4'h8, 2'b00, 1'b0, 1'b0}, // R8 new activity
        {2'd2, 1'b1, 4'd0, 4'h0, 2'b00, 1'b1, 1'b0}, // R8 drained
        {2'd2, 1'b0, 4'd0, 4'h0, 2'b00, 1'b0, 1'b0}, // R7
        {2'd2, 1'b1, 4'd2, 4'h0, 2'b00, 1'b0, 1'b0}, // R2
        {2'd2, 1'b0, 4'd0, 4'h0, 2'b00, 1'b0, 1'b0}, // R7 abort during drain
        {2'd2, 1'b0, 4'd0, 4'h0, 2'b00, 1'b0, 1'b0}, // R7 no late ack
        {2'd3, 1'b1, 4'd0, 4'h0, 2'b00, 1'b1, 1'b0}  // R3 idle, no event
    };

    task automatic check(input string tag, input logic act, input logic exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: got %b expected %b", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [1:0] p, input logic r, input logic [3:0] t,
                         input logic [3:0] i, input logic [1:0] d);
        @(negedge clk);
        pol = p; req = r; txn = t; irq = i; dma = d;
        @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R9 ack after reset", ack, 1'b0);
        check("R9 wake after reset", wake, 1'b0);
        rst_n = 1'b1;

        for (int k = 0; k < NV; k++) begin
            drive(VEC[k][14:13], VEC[k][12], VEC[k][11:8], VEC[k][7:4], VEC[k][3:2]);
            check($sformatf("vec %0d ack", k), ack, VEC[k][1]);
            check($sformatf("vec %0d wake", k), wake, VEC[k][0]);
            check($sformatf("R4 vec %0d nw ack", k), ack_nw, VEC[k][1]);
            check($sformatf("R4 vec %0d nw wake", k), wake_nw, 1'b0);
        end

        // R3: a DMA line rising while idle also wakes
        drive(2'd3, 1'b1, 4'd0, 4'h0, 2'b01);
        check("R3 dma wake", wake, 1'b1);
        check("R4 dma nw wake", wake_nw, 1'b0);

        // R9: reset while idle and waking
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check("R9 ack in reset", ack, 1'b0);
        check("R9 wake in reset", wake, 1'b0);
        req = 1'b0; dma = '0;
        @(negedge clk); rst_n = 1'b1;

        // R1: force with held activity, then no wake from level already high
        drive(2'd0, 1'b1, 4'd0, 4'h4, 2'b00);
        check("R1 force ack", ack, 1'b1);
        drive(2'd0, 1'b0, 4'd0, 4'h0, 2'b00);
        check("R7 exit force", ack, 1'b0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule